// File: doc/BRIEF.md
# Unary Integer Execution Unit with T Flag

This unit executes the single-operand integer instructions of a 32-bit RISC core: decrement with zero test, sign and zero extension of a byte or a 16-bit word, two's-complement negation, and negation with borrow. The issue stage presents a 16-bit instruction word together with the two operand values that the register file has read for it: the source operand (Rm) and the destination operand (Rn). One clock edge later the unit presents a result, a destination register index and a write enable.

The unit keeps the core's one-bit T flag. Decrement writes a zero indication into T. Negate-with-borrow reads T as a borrow input and writes the new borrow back into T. Every other operation leaves T unchanged. A word that belongs to none of these operations produces no write and raises an illegal indication. Two negate-with-borrow steps in sequence, low word first with T clear, negate a 64-bit value.

Top module: `unary_alu`

## Requirements
- R1: While reset is asserted, and on the first output after reset, `wr_en`, `illegal` and `t_flag` are all 0.
- R2: The word 0100nnnn00010000 writes Rn minus 1 and sets T to 1 exactly when that result is zero. A value of 0 wraps to 0xFFFFFFFF and clears T.
- R3: The word 0110nnnnmmmm1110 writes Rm[7:0] sign-extended to 32 bits. The word 0110nnnnmmmm1111 writes Rm[15:0] sign-extended.
- R4: The word 0110nnnnmmmm1100 writes Rm[7:0] zero-extended. The word 0110nnnnmmmm1101 writes Rm[15:0] zero-extended.
- R5: The word 0110nnnnmmmm1011 writes 0 minus Rm modulo 2^32, so 0x80000000 gives 0x80000000.
- R6: The word 0110nnnnmmmm1010 writes 0 minus Rm minus T modulo 2^32, and sets T to 1 exactly when Rm is nonzero or the old T is 1. Two such steps in sequence negate a 64-bit value.
- R7: The four extend operations and the plain negate leave T unchanged.
- R8: Any other issued word gives `wr_en` 0 and `illegal` 1, and leaves T unchanged.
- R9: Results appear on the outputs after the clock edge that captures the issue. `wr_idx` equals the nnnn field, bits [11:8] of the word.
- R10: A cycle without `issue` gives `wr_en` 0 and `illegal` 0 on the next output, and T holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| rm_val | input | 32 | Source operand value |
| rn_val | input | 32 | Destination operand value (read by decrement) |
| wr_en | output | 1 | Write the result to the destination register |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 32 | Result value |
| t_flag | output | 1 | Current T flag |
| illegal | output | 1 | The issued word was not a unary operation |

## Verification
The assertions assume that `issue`, `instr` and both operands hold known values at every clock edge after reset, and that each issued word is decoded from its bits alone, with no history. The bench drives every input on the falling edge, so each value is settled well before the capturing edge. In every cycle it also drives a known `issue`, either a valid opcode or a random word that may or may not decode. Random operands are mixed with the directed edges, such as zero, one and 0x80000000, so that the zero test, the wrap and the borrow conditions are each reached from both sides.

// File: rtl/unary_alu.sv
module unary_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [15:0]  instr,
  input  logic [W-1:0] rm_val,
  input  logic [W-1:0] rn_val,
  output logic         wr_en,
  output logic [3:0]   wr_idx,
  output logic [W-1:0] wr_data,
  output logic         t_flag,
  output logic         illegal
);

  logic is_dt, grp6, is_exsb, is_exsw, is_exub, is_exuw, is_neg, is_negc, known;
  logic [W-1:0] dec_v, res;
  logic [W:0]   negc_full;
  logic         t_next;

  assign is_dt   = (instr[15:12] == 4'h4) && (instr[7:0] == 8'h10);
  assign grp6    = (instr[15:12] == 4'h6);
  assign is_exsb = grp6 && (instr[3:0] == 4'hE);
  assign is_exsw = grp6 && (instr[3:0] == 4'hF);
  assign is_exub = grp6 && (instr[3:0] == 4'hC);
  assign is_exuw = grp6 && (instr[3:0] == 4'hD);
  assign is_neg  = grp6 && (instr[3:0] == 4'hB);
  assign is_negc = grp6 && (instr[3:0] == 4'hA);
  assign known   = is_dt | is_exsb | is_exsw | is_exub | is_exuw | is_neg | is_negc;

  assign dec_v     = rn_val - W'(1);
  assign negc_full = {1'b0, {W{1'b0}}} - {1'b0, rm_val} - (W+1)'(t_flag);

  always_comb begin
    res    = '0;
    t_next = t_flag;
    if (is_dt) begin
      res    = dec_v;
      t_next = (dec_v == '0);
    end else if (is_exsb) res = {{(W-8){rm_val[7]}}, rm_val[7:0]};
    else if (is_exsw)     res = {{(W-16){rm_val[15]}}, rm_val[15:0]};
    else if (is_exub)     res = {{(W-8){1'b0}}, rm_val[7:0]};
    else if (is_exuw)     res = {{(W-16){1'b0}}, rm_val[15:0]};
    else if (is_neg)      res = '0 - rm_val;
    else if (is_negc) begin
      res    = negc_full[W-1:0];
      t_next = negc_full[W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      t_flag  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      wr_en   <= issue && known;
      illegal <= issue && !known;
      wr_idx  <= instr[11:8];
      wr_data <= res;
      if (issue && known) t_flag <= t_next;
    end
  end

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && illegal));
  assert_dt_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_dt |=> wr_en && (t_flag == (wr_data == '0)));
  assert_sext_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_exsb |=> wr_data[W-1:8] == {(W-8){wr_data[7]}});
  assert_zext_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_exuw |=> wr_data[W-1:16] == '0);
  assert_negc_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_negc |=> t_flag == (($past(rm_val) != '0) || $past(t_flag)));
  assert_t_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (is_exsb || is_exsw || is_exub || is_exuw || is_neg) |=> $stable(t_flag));
  assert_undecoded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !known |=> illegal && !wr_en && $stable(t_flag));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !wr_en && !illegal && $stable(t_flag));

endmodule

// File: tb/tb_unary_alu.sv
module tb_unary_alu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        issue = 0;
  logic [15:0] instr = '0;
  logic [31:0] rm_val = '0, rn_val = '0;
  logic        wr_en, t_flag, illegal;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;

  int n_cmp = 0, n_bad = 0;
  logic m_t = 0;

  always #2.5 clk = ~clk;

  unary_alu dut (.clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .rm_val(rm_val),
                 .rn_val(rn_val), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
                 .t_flag(t_flag), .illegal(illegal));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [15:0] w);
    if (w[15:12] == 4'h4 && w[7:0] == 8'h10) return "R2";
    if (w[15:12] == 4'h6) case (w[3:0])
      4'hE, 4'hF: return "R3";
      4'hC, 4'hD: return "R4";
      4'hB: return "R5";
      4'hA: return "R6";
      default: return "R8";
    endcase
    return "R8";
  endfunction

  task automatic model(input logic [15:0] w, input logic [31:0] rm, input logic [31:0] rn,
                       inout logic t, output logic we, output logic [31:0] d);
    logic [32:0] full;
    we = 1; d = '0;
    if (w[15:12] == 4'h4 && w[7:0] == 8'h10) begin
      d = rn - 1; t = (d == 0);
    end else if (w[15:12] == 4'h6 && w[3:0] == 4'hE) d = {{24{rm[7]}}, rm[7:0]};
    else if (w[15:12] == 4'h6 && w[3:0] == 4'hF) d = {{16{rm[15]}}, rm[15:0]};
    else if (w[15:12] == 4'h6 && w[3:0] == 4'hC) d = {24'h0, rm[7:0]};
    else if (w[15:12] == 4'h6 && w[3:0] == 4'hD) d = {16'h0, rm[15:0]};
    else if (w[15:12] == 4'h6 && w[3:0] == 4'hB) d = -rm;
    else if (w[15:12] == 4'h6 && w[3:0] == 4'hA) begin
      full = 33'd0 - {1'b0, rm} - {32'd0, t};
      d = full[31:0]; t = (rm != 0) || t;
    end else we = 0;
  endtask

  // drive at falling edge, capture at rising edge, compare at next falling edge
  task automatic step(input logic iss, input logic [15:0] w, input logic [31:0] rm,
                      input logic [31:0] rn);
    logic we;
    logic [31:0] d;
    string r;
    issue = iss; instr = w; rm_val = rm; rn_val = rn;
    @(negedge clk);
    if (!iss) begin
      chk("R10 wr_en", {31'd0, wr_en}, 0);
      chk("R10 illegal", {31'd0, illegal}, 0);
      chk("R10 t", {31'd0, t_flag}, {31'd0, m_t});
      return;
    end
    model(w, rm, rn, m_t, we, d);
    r = req_of(w);
    chk({r, " wr_en"}, {31'd0, wr_en}, {31'd0, we});
    chk({"R8 illegal"}, {31'd0, illegal}, {31'd0, !we});
    chk({r, (r == "R2" || r == "R6") ? " t" : " t R7"}, {31'd0, t_flag}, {31'd0, m_t});
    if (we) begin
      chk({r, " data"}, wr_data, d);
      chk("R9 wr_idx", {28'd0, wr_idx}, {28'd0, w[11:8]});
    end
  endtask

  initial begin
    #(5 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] ops [8];
    void'($urandom(32'd1234));
    ops[0] = 16'h4010; ops[1] = 16'h600E; ops[2] = 16'h600F; ops[3] = 16'h600C;
    ops[4] = 16'h600D; ops[5] = 16'h600B; ops[6] = 16'h600A; ops[7] = 16'h0009;
    repeat (3) @(negedge clk);
    chk("R1 wr_en", {31'd0, wr_en}, 0);
    chk("R1 illegal", {31'd0, illegal}, 0);
    chk("R1 t", {31'd0, t_flag}, 0);
    rst_n = 1;
    step(0, 16'h0, 0, 0);
    // directed corners
    step(1, 16'h4310, 0, 32'h1);            // R2 reaches zero, T=1
    step(1, 16'h4510, 0, 32'h0);            // R2 wraps, T=0
    step(1, 16'h4110, 0, 32'h0);            // T stays 0
    step(1, 16'h6a0E, 32'h0000_0080, 0);    // R3 byte
    step(1, 16'h6a0F, 32'h0001_8000, 0);    // R3 word
    step(1, 16'h620C, 32'h0000_ABCD, 0);    // R4 byte
    step(1, 16'h620D, 32'hFFFF_8765, 0);    // R4 word
    step(1, 16'h670B, 32'h8000_0000, 0);    // R5 most negative
    step(1, 16'h670B, 32'h0000_0000, 0);    // R5 zero
    // R6 64-bit negate of 0x00000001_00000000: T clear first
    step(1, 16'h4010, 0, 32'h5);
    step(1, 16'h610A, 32'h0000_0000, 0);    // low: 0, T=0
    step(1, 16'h620A, 32'h0000_0001, 0);    // high: FFFFFFFF, T=1
    // R6 64-bit negate of 0x00000000_00000001
    step(1, 16'h4010, 0, 32'h5);
    step(1, 16'h610A, 32'h0000_0001, 0);    // low FFFFFFFF, T=1
    step(1, 16'h620A, 32'h0000_0000, 0);    // high FFFFFFFF, T=1
    step(1, 16'h600B, 32'h1234_5678, 0);    // R7: T still 1
    step(1, 16'h6003, 32'h1, 32'h2);        // R8 in group, T kept
    step(1, 16'hF123, 32'h1, 32'h2);        // R8 other group
    step(0, 16'h4010, 32'h1, 32'h1);        // R10 idle holds T
    // random
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] w;
      logic [31:0] a, b;
      int k;
      k = $urandom_range(0, 9);
      if (k < 8) w = (ops[k] & 16'hF00F) | (16'($urandom) & 16'h0FF0);
      else w = 16'($urandom);
      if (k == 0) w[7:0] = 8'h10;
      case ($urandom_range(0, 5))
        0: a = 0; 1: a = 32'h8000_0000; 2: a = 1;
        default: a = $urandom;
      endcase
      case ($urandom_range(0, 3))
        0: b = 1; 1: b = 0;
        default: b = $urandom;
      endcase
      step($urandom_range(0, 7) != 0, w, a, b);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule